// File: doc/BRIEF.md
# Port Status LED Driver for a Two-Port Media Converter

This block turns the status signals of a copper port and a fiber port into the front-panel LED pins of a media converter. The copper port has link, speed and duplex LEDs. The fiber port has link, duplex, signal-detect and far-end-fault LEDs. Each LED shows a steady state taken from its status input. When there is traffic on a port, its link LED flashes. When a half-duplex port sees a collision, its duplex LED flashes. The far-end-fault LED runs its own repeating pattern for as long as the fault pattern is being received. Every LED pin is active low, so a pin driven low means the LED is lit.

Timing is counted in millisecond ticks. A prescaler divides the system clock, which is 25 MHz in the default build, by a parameter. Every flash or fault cycle starts on a tick boundary. Activity and collision pulses are one clock wide. A pulse is stored until the next cycle boundary. It never restarts a cycle that is already running. When the condition that allows a flash goes away, the LED falls back at once to its steady indication.

Top module: `mc_status_led`

## Requirements
- R1: After reset, with every status input low, all seven LED pins are high (unlit). A pin is low exactly when its LED is lit.
- R2: With the link up, an activity pulse starts a flash cycle that is PERIOD_MS ticks long. The link LED is lit for the first ON_MS ticks and dark for the remaining PERIOD_MS-ON_MS ticks. After that it returns to steady lit.
- R3: Activity that arrives during a running cycle does not restart or stretch that cycle. If any activity was seen, a second cycle begins right at the boundary of the first.
- R4: While the link is down, the link LED is dark within the same cycle, any pending flash is discarded, and activity pulses are ignored.
- R5: The duplex LED is lit steadily for full duplex (full input = 1) and dark for half duplex.
- R6: In half duplex, a collision pulse produces the same lit-then-dark flash cycle on the duplex LED. In full duplex, collision pulses have no effect.
- R7: The speed LED is lit when the 100 Mb/s input is 1 and dark when it is 0.
- R8: The signal-detect LED is lit while the fiber signal-detect input is 1.
- R9: While the far-end-fault input is 1, its LED repeats a cycle of FEF_ON_MS ticks lit followed by PERIOD_MS-FEF_ON_MS ticks dark. When the input is 0, the LED is dark.
- R10: One tick is DIV clock cycles. A cycle starts at the first tick that coincides with or follows the triggering pulse.
- R11: The two ports run independently: a flash on the fiber link LED leaves the copper link LED in its steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (25 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tp_link_up | input | 1 | Copper port link is up |
| tp_act | input | 1 | Copper port activity pulse |
| tp_speed100 | input | 1 | Copper port runs at 100 Mb/s |
| tp_full | input | 1 | Copper port is full duplex |
| tp_col | input | 1 | Copper port collision pulse |
| fx_link_up | input | 1 | Fiber port link is up |
| fx_act | input | 1 | Fiber port activity pulse |
| fx_full | input | 1 | Fiber port is full duplex |
| fx_col | input | 1 | Fiber port collision pulse |
| fx_sig_det | input | 1 | Fiber signal detected |
| fx_fef_det | input | 1 | Far-end-fault pattern being received |
| tp_link_led_n | output | 1 | Copper link/activity LED, low = lit |
| tp_speed_led_n | output | 1 | Copper speed LED, low = lit |
| tp_duplex_led_n | output | 1 | Copper duplex/collision LED, low = lit |
| fx_link_led_n | output | 1 | Fiber link/activity LED, low = lit |
| fx_duplex_led_n | output | 1 | Fiber duplex/collision LED, low = lit |
| fx_sd_led_n | output | 1 | Fiber signal-detect LED, low = lit |
| fx_fef_led_n | output | 1 | Far-end-fault LED, low = lit |

## Verification
The bench builds the block with DIV=4, PERIOD_MS=10, ON_MS=2 and FEF_ON_MS=8. These values keep the 20/80 and 80/20 duty ratios, but a full flash cycle takes only 40 clocks. At that length, every lit and dark phase can be measured to the exact clock. The bench can also cover back-to-back retriggered cycles, a link drop in the middle of a cycle, and several fault periods within a short run. With the default DIV of 25000, a single cycle would take millions of clocks.

// File: rtl/mcled_pkg.sv
package mcled_pkg;
  // Slots of the flash engine array
  localparam int unsigned N_FLASH     = 5;
  localparam int unsigned IX_TP_LINK  = 0;
  localparam int unsigned IX_TP_DPX   = 1;
  localparam int unsigned IX_FX_LINK  = 2;
  localparam int unsigned IX_FX_DPX   = 3;
  localparam int unsigned IX_FEF      = 4;
endpackage

// File: rtl/mcled_ms_tick.sv
module mcled_ms_tick #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/mcled_flash.sv
module mcled_flash #(
  parameter int unsigned PERIOD_MS = 100,
  parameter int unsigned ON_MS     = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  input  logic trig,
  input  logic steady,
  output logic lit
);
  localparam int unsigned CW = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD_MS - 1);

  logic          active_q, active_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == LAST_C);

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    if (!cond) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
      cnt_d    = '0;
    end else begin
      pend_d = pend_q | trig;
      if (tick) begin
        if (active_q && !at_end) begin
          cnt_d = cnt_q + 1'b1;
        end else if (pend_d) begin
          active_d = 1'b1;
          pend_d   = 1'b0;
          cnt_d    = '0;
        end else begin
          active_d = 1'b0;
          cnt_d    = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      cnt_q    <= cnt_d;
    end
  end

  // Flash phase overrides the steady level only while the condition holds
  assign lit = (cond && active_q) ? (32'(cnt_q) < ON_MS) : steady;
endmodule

// File: rtl/mc_status_led.sv
module mc_status_led #(
  parameter int unsigned DIV       = 25000,
  parameter int unsigned PERIOD_MS = 100,
  parameter int unsigned ON_MS     = 20,
  parameter int unsigned FEF_ON_MS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tp_link_up,
  input  logic tp_act,
  input  logic tp_speed100,
  input  logic tp_full,
  input  logic tp_col,
  input  logic fx_link_up,
  input  logic fx_act,
  input  logic fx_full,
  input  logic fx_col,
  input  logic fx_sig_det,
  input  logic fx_fef_det,
  output logic tp_link_led_n,
  output logic tp_speed_led_n,
  output logic tp_duplex_led_n,
  output logic fx_link_led_n,
  output logic fx_duplex_led_n,
  output logic fx_sd_led_n,
  output logic fx_fef_led_n
);
  import mcled_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges
  logic rs_meta_q, rs_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end
  assign rst_core_n = rs_q;

  logic ms_tick;
  mcled_ms_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_core_n),
    .tick (ms_tick)
  );

  logic [N_FLASH-1:0] fl_cond, fl_trig, fl_steady, fl_lit;

  always_comb begin
    fl_cond   = '0;
    fl_trig   = '0;
    fl_steady = '0;
    fl_cond[IX_TP_LINK]   = tp_link_up;
    fl_trig[IX_TP_LINK]   = tp_act;
    fl_steady[IX_TP_LINK] = tp_link_up;
    fl_cond[IX_TP_DPX]    = ~tp_full;
    fl_trig[IX_TP_DPX]    = tp_col;
    fl_steady[IX_TP_DPX]  = tp_full;
    fl_cond[IX_FX_LINK]   = fx_link_up;
    fl_trig[IX_FX_LINK]   = fx_act;
    fl_steady[IX_FX_LINK] = fx_link_up;
    fl_cond[IX_FX_DPX]    = ~fx_full;
    fl_trig[IX_FX_DPX]    = fx_col;
    fl_steady[IX_FX_DPX]  = fx_full;
    // Fault pattern: always retriggered, so cycles repeat back to back
    fl_cond[IX_FEF]       = fx_fef_det;
    fl_trig[IX_FEF]       = 1'b1;
    fl_steady[IX_FEF]     = 1'b0;
  end

  for (genvar i = 0; i < N_FLASH; i++) begin : g_fl
    localparam int unsigned ON_I = (i == IX_FEF) ? FEF_ON_MS : ON_MS;
    mcled_flash #(.PERIOD_MS(PERIOD_MS), .ON_MS(ON_I)) u_fl (
      .clk   (clk),
      .rst_n (rst_core_n),
      .tick  (ms_tick),
      .cond  (fl_cond[i]),
      .trig  (fl_trig[i]),
      .steady(fl_steady[i]),
      .lit   (fl_lit[i])
    );
  end

  assign tp_link_led_n   = ~fl_lit[IX_TP_LINK];
  assign tp_duplex_led_n = ~fl_lit[IX_TP_DPX];
  assign fx_link_led_n   = ~fl_lit[IX_FX_LINK];
  assign fx_duplex_led_n = ~fl_lit[IX_FX_DPX];
  assign fx_fef_led_n    = ~fl_lit[IX_FEF];
  assign tp_speed_led_n  = ~tp_speed100;
  assign fx_sd_led_n     = ~fx_sig_det;
endmodule

// File: rtl/mcled_sva.sv
module mcled_sva #(
  parameter int unsigned DIV       = 25000,
  parameter int unsigned PERIOD_MS = 100,
  parameter int unsigned ON_MS     = 20,
  parameter int unsigned FEF_ON_MS = 80
) (
  input logic clk,
  input logic rst_n,
  input logic tp_link_up,
  input logic tp_speed100,
  input logic tp_full,
  input logic fx_link_up,
  input logic fx_sig_det,
  input logic fx_fef_det,
  input logic tp_link_led_n,
  input logic tp_speed_led_n,
  input logic tp_duplex_led_n,
  input logic fx_link_led_n,
  input logic fx_sd_led_n,
  input logic fx_fef_led_n
);
  localparam int unsigned DARK_MAX = (PERIOD_MS - ON_MS) * DIV;
  localparam int unsigned LIT_MAX  = ON_MS * DIV;
  localparam int unsigned FEF_MAX  = FEF_ON_MS * DIV;

  int unsigned link_dark_run, dpx_lit_run, fef_lit_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_dark_run <= 0;
      dpx_lit_run   <= 0;
      fef_lit_run   <= 0;
    end else begin
      link_dark_run <= (tp_link_up && tp_link_led_n) ? link_dark_run + 1 : 0;
      dpx_lit_run   <= (!tp_full && !tp_duplex_led_n) ? dpx_lit_run + 1 : 0;
      fef_lit_run   <= (fx_fef_det && !fx_fef_led_n) ? fef_lit_run + 1 : 0;
    end
  end

  assert_dark_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_dark_run <= DARK_MAX);
  assert_tp_down_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_link_up |-> tp_link_led_n);
  assert_fx_down_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fx_link_up |-> fx_link_led_n);
  assert_full_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tp_full |-> !tp_duplex_led_n);
  assert_col_lit_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dpx_lit_run <= LIT_MAX);
  assert_speed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tp_speed_led_n == !tp_speed100);
  assert_sd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fx_sd_led_n == !fx_sig_det);
  assert_fef_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fx_fef_det |-> fx_fef_led_n);
  assert_fef_lit_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fef_lit_run <= FEF_MAX);
endmodule

bind mc_status_led mcled_sva #(
  .DIV(DIV), .PERIOD_MS(PERIOD_MS), .ON_MS(ON_MS), .FEF_ON_MS(FEF_ON_MS)
) u_sva (.*);

// File: tb/tb_mc_status_led.sv
module tb_mc_status_led;
  localparam int unsigned DIV = 4;
  localparam int unsigned PER = 10;
  localparam int unsigned ON  = 2;
  localparam int unsigned FON = 8;
  localparam int CYC   = PER * DIV;
  localparam int LIT   = ON * DIV;
  localparam int DARK  = (PER - ON) * DIV;
  localparam int FLIT  = FON * DIV;
  localparam int FDARK = (PER - FON) * DIV;
  localparam int WD    = 150000;

  logic clk, rst_n;
  logic tp_link_up, tp_act, tp_speed100, tp_full, tp_col;
  logic fx_link_up, fx_act, fx_full, fx_col, fx_sig_det, fx_fef_det;
  logic tp_link_led_n, tp_speed_led_n, tp_duplex_led_n;
  logic fx_link_led_n, fx_duplex_led_n, fx_sd_led_n, fx_fef_led_n;

  int tests, fails, cyc;

  mc_status_led #(.DIV(DIV), .PERIOD_MS(PER), .ON_MS(ON), .FEF_ON_MS(FON)) dut (
    .clk(clk), .rst_n(rst_n),
    .tp_link_up(tp_link_up), .tp_act(tp_act), .tp_speed100(tp_speed100),
    .tp_full(tp_full), .tp_col(tp_col),
    .fx_link_up(fx_link_up), .fx_act(fx_act), .fx_full(fx_full), .fx_col(fx_col),
    .fx_sig_det(fx_sig_det), .fx_fef_det(fx_fef_det),
    .tp_link_led_n(tp_link_led_n), .tp_speed_led_n(tp_speed_led_n),
    .tp_duplex_led_n(tp_duplex_led_n), .fx_link_led_n(fx_link_led_n),
    .fx_duplex_led_n(fx_duplex_led_n), .fx_sd_led_n(fx_sd_led_n),
    .fx_fef_led_n(fx_fef_led_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Observed pin selectors
  localparam int S_TPL = 0, S_TPD = 1, S_FXL = 2, S_FEF = 3;

  // Table: [11:6] inputs {tp_link,tp_spd,tp_full,fx_link,fx_full,sd}
  //        [5:0]  expected {tp_link_n,tp_spd_n,tp_dpx_n,fx_link_n,fx_dpx_n,sd_n}
  localparam logic [11:0] VECS [6] = '{
    12'b000000_111111,
    12'b111111_000000,
    12'b100000_011111,
    12'b011010_100101,
    12'b000101_111010,
    12'b101100_010011
  };

  function automatic logic obs(int s);
    case (s)
      S_TPL:   return tp_link_led_n;
      S_TPD:   return tp_duplex_led_n;
      S_FXL:   return fx_link_led_n;
      default: return fx_fef_led_n;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_for(int s, logic lvl, int lim, output int n);
    n = 0;
    while (obs(s) != lvl && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_len(int s, logic lvl, int lim, output int n);
    n = 0;
    while (obs(s) == lvl && n < lim) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_tp_act();
    tp_act = 1'b1; @(negedge clk); tp_act = 1'b0;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WD);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n, w;
    tests = 0; fails = 0;
    rst_n = 1'b0;
    {tp_link_up, tp_act, tp_speed100, tp_full, tp_col} = '0;
    {fx_link_up, fx_act, fx_full, fx_col, fx_sig_det, fx_fef_det} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state: all pins unlit
    chk("R1 reset", {tp_link_led_n, tp_speed_led_n, tp_duplex_led_n, fx_link_led_n,
                     fx_duplex_led_n, fx_sd_led_n, fx_fef_led_n}, 7'h7f);

    // Steady-state table (R1/R5/R7/R8)
    for (int i = 0; i < 6; i++) begin
      {tp_link_up, tp_speed100, tp_full, fx_link_up, fx_full, fx_sig_det} = VECS[i][11:6];
      repeat (2) @(negedge clk);
      chk("R1/R5/R7/R8 table",
          {tp_link_led_n, tp_speed_led_n, tp_duplex_led_n, fx_link_led_n,
           fx_duplex_led_n, fx_sd_led_n}, VECS[i][5:0]);
    end

    // R2 / R10: single flash on copper link
    tp_link_up = 1; tp_full = 1; fx_link_up = 0; fx_full = 1;
    repeat (2 * CYC) @(negedge clk);
    pulse_tp_act();
    wait_for(S_TPL, 1'b1, 4 * CYC, w);
    chk("R10 start latency in window", int'(w >= LIT - 1 && w <= LIT + DIV + 1), 1);
    run_len(S_TPL, 1'b1, 4 * CYC, n);
    chk("R2 dark phase", n, DARK);
    run_len(S_TPL, 1'b0, 2 * CYC, n);
    chk("R2 back to steady lit", n, 2 * CYC);

    // R3: pulse during the dark phase neither restarts nor stretches it
    pulse_tp_act();
    wait_for(S_TPL, 1'b1, 4 * CYC, w);
    pulse_tp_act();
    run_len(S_TPL, 1'b1, 4 * CYC, n);
    chk("R3 dark not restarted", n + 1, DARK);
    run_len(S_TPL, 1'b0, 4 * CYC, n);
    chk("R3 second cycle lit", n, LIT);
    run_len(S_TPL, 1'b1, 4 * CYC, n);
    chk("R3 second cycle dark", n, DARK);
    run_len(S_TPL, 1'b0, 2 * CYC, n);
    chk("R3 no third cycle", n, 2 * CYC);

    // R4: link drop cancels flash; activity while down ignored
    pulse_tp_act();
    tp_link_up = 0;
    @(negedge clk);
    chk("R4 dark when down", tp_link_led_n, 1);
    pulse_tp_act();
    tp_link_up = 1;
    @(negedge clk);
    run_len(S_TPL, 1'b0, 2 * CYC, n);
    chk("R4 pending discarded", n, 2 * CYC);

    // R6: half-duplex collision flash, full-duplex collision ignored
    tp_full = 0;
    repeat (2) @(negedge clk);
    chk("R5 half dark", tp_duplex_led_n, 1);
    tp_col = 1; @(negedge clk); tp_col = 0;
    wait_for(S_TPD, 1'b0, 2 * CYC, w);
    run_len(S_TPD, 1'b0, 4 * CYC, n);
    chk("R6 collision lit", n, LIT);
    run_len(S_TPD, 1'b1, 2 * CYC, n);
    chk("R6 then dark", n, 2 * CYC);
    tp_full = 1;
    @(negedge clk);
    tp_col = 1; @(negedge clk); tp_col = 0;
    run_len(S_TPD, 1'b0, 2 * CYC, n);
    chk("R6 full-duplex collision ignored", n, 2 * CYC);

    // R11: fiber link flash leaves copper link steady
    fx_link_up = 1;
    repeat (2) @(negedge clk);
    fx_act = 1; @(negedge clk); fx_act = 0;
    wait_for(S_FXL, 1'b1, 4 * CYC, w);
    chk("R11 copper link steady", tp_link_led_n, 0);
    run_len(S_FXL, 1'b1, 4 * CYC, n);
    chk("R11 fiber dark phase", n, DARK);

    // R9: far-end-fault pattern
    fx_fef_det = 1;
    wait_for(S_FEF, 1'b0, 2 * CYC, w);
    run_len(S_FEF, 1'b0, 4 * CYC, n);
    chk("R9 fault lit", n, FLIT);
    run_len(S_FEF, 1'b1, 4 * CYC, n);
    chk("R9 fault dark", n, FDARK);
    run_len(S_FEF, 1'b0, 4 * CYC, n);
    chk("R9 fault repeats", n, FLIT);
    fx_fef_det = 0;
    @(negedge clk);
    run_len(S_FEF, 1'b1, 2 * CYC, n);
    chk("R9 idle dark", n, 2 * CYC);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule